// File: doc/BRIEF.md
# Scheduled Stream Word Router

This block sits between a bus write port and a data-flow accelerator that consumes two input streams: a wide stream of 16-bit samples and a narrow stream of 8-bit samples. The driver writes one plain, ordered series of 32-bit words. The block carries no address for each stream. It decides which stream each word belongs to from a fixed schedule, unpacks the word into samples of that stream's width, and pushes the samples into a small FIFO per stream. The accelerator pops samples from the FIFOs.

A run has three phases, taken in order:
- **Lead-in.** A short burst of words for the wide stream only.
- **Body.** A pattern repeated a programmed number of times. Each repetition is a burst of wide-stream words followed by a burst of narrow-stream words.
- **Tail.** A short burst of words for the narrow stream only.

Each burst length is a parameter. The repetition count is sampled when a run is started. When the word that belongs to the destination FIFO cannot fit, the bus ready is withheld, which stalls the driver. A word that arrives after the tail has finished is taken and thrown away, and it raises a sticky error flag.

Top module: `stream_word_router`

## Requirements
- R1: After reset, `word_ready_o` is 0, both FIFOs are empty (`a_valid_o` = 0, `b_valid_o` = 0), and `err_o` is 0.
- R2: After a start, the first `LEAD_WORDS` accepted words (1 by default) go to the wide (A) FIFO.
- R3: In the body, each repetition routes `BODY_A_WORDS` words (10) to A, then `BODY_B_WORDS` words (5) to B. The pattern repeats `reps_i` times, where `reps_i` is the value held on the start cycle.
- R4: Lane order: an A word yields bits [15:0] and then bits [31:16]. A B word yields bits [7:0], [15:8], [23:16] and [31:24], in that order at the FIFO output.
- R5: After the last repetition, `TAIL_WORDS` words (1) go to B. When `reps_i` = 0, the body is skipped and the tail follows the lead-in directly.
- R6: `word_ready_o` is 0 while the destination FIFO of the next word has fewer free entries than that word has samples. A word offered while ready is 0 is not taken.
- R7: Each FIFO holds 20 samples. With A not drained, the lead-in word and the first 9 body words (20 samples) are all accepted before the stall.
- R8: A word offered after the tail has completed is accepted and dropped: no sample reaches either FIFO. From the next cycle on, `err_o` is 1 and stays 1 until the next start, which clears it.
- R9: `word_ready_o` is 0 before the first start and during any cycle in which `start_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new run; samples `reps_i` |
| reps_i | input | 8 | Number of body pattern repetitions |
| word_valid_i | input | 1 | Bus word offered |
| word_data_i | input | 32 | Bus word |
| word_ready_o | output | 1 | Bus word can be taken this cycle |
| a_pop_i | input | 1 | Consumer takes one A sample |
| a_data_o | output | 16 | Head A sample |
| a_valid_o | output | 1 | A FIFO not empty |
| b_pop_i | input | 1 | Consumer takes one B sample |
| b_data_o | output | 8 | Head B sample |
| b_valid_o | output | 1 | B FIFO not empty |
| err_o | output | 1 | Word arrived after the run finished |

## Verification
The assertions assume the burst-length parameters are nonzero. They also assume the consumer pops a FIFO only while it reports valid, and that `start_i` is asserted only between whole runs, so that no word is in flight when a run restarts.

The stimulus respects these assumptions:
- It holds each word stable until ready is seen.
- It pops only when valid.
- It raises start only after a run's words have all been sent, including the deliberate late word used to provoke the error flag.

// File: rtl/swr_pkg.sv
package swr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_BODY_A,
    PH_BODY_B,
    PH_TAIL,
    PH_DONE
  } phase_e;

  // Ring index advance without a divider: off never exceeds depth.
  function automatic int unsigned ring_add(int unsigned base, int unsigned off,
                                           int unsigned depth);
    int unsigned s;
    s = base + off;
    return (s >= depth) ? s - depth : s;
  endfunction

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // True when a FIFO with 'level' entries out of 'depth' can take 'lanes' more.
  function automatic logic has_room(int unsigned level, int unsigned lanes,
                                    int unsigned depth);
    return (level + lanes) <= depth;
  endfunction

endpackage

// File: rtl/swr_fifo.sv
module swr_fifo
  import swr_pkg::*;
#(
  parameter int SW    = 16,
  parameter int LANES = 2,
  parameter int DEPTH = 20,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  logic [LANES*SW-1:0]   din,
  input  logic                  pop,
  output logic [SW-1:0]         dout,
  output logic                  valid,
  output logic                  room,
  output logic [CW-1:0]         level
);

  logic [SW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          pop_ok;

  assign valid  = (level != '0);
  assign pop_ok = pop && valid;
  assign room   = has_room(32'(level), LANES, DEPTH);
  assign dout   = mem[rd_ptr];

  // Multi-lane write: lane 0 (low bits) lands first in read order.
  always_ff @(posedge clk) begin
    if (push) begin
      for (int i = 0; i < LANES; i++) begin
        mem[PW'(ring_add(32'(wr_ptr), i, DEPTH))] <= din[i*SW +: SW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push)   wr_ptr <= PW'(ring_add(32'(wr_ptr), LANES, DEPTH));
      if (pop_ok) rd_ptr <= PW'(ring_add(32'(rd_ptr), 1, DEPTH));
      level <= level + (push ? CW'(LANES) : CW'(0)) - CW'(pop_ok);
    end
  end

endmodule

// File: rtl/swr_sched.sv
module swr_sched
  import swr_pkg::*;
#(
  parameter int LEAD_WORDS   = 1,
  parameter int BODY_A_WORDS = 10,
  parameter int BODY_B_WORDS = 5,
  parameter int TAIL_WORDS   = 1,
  parameter int REP_W        = 8,
  localparam int MAXSEG      = max4(LEAD_WORDS, BODY_A_WORDS, BODY_B_WORDS, TAIL_WORDS),
  localparam int SGW         = $clog2(MAXSEG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [REP_W-1:0] reps_i,
  input  logic             word_valid,
  input  logic             a_room,
  input  logic             b_room,
  output logic             ready,
  output logic             fire,
  output logic             to_a,
  output logic             to_b,
  output logic             in_done,
  output logic             err
);

  phase_e           phase;
  logic [SGW-1:0]   seg_cnt;
  logic [REP_W-1:0] reps_left;
  logic             seg_last;
  logic             dest_a, dest_b;

  function automatic int unsigned seg_len(phase_e p);
    case (p)
      PH_LEAD:   return LEAD_WORDS;
      PH_BODY_A: return BODY_A_WORDS;
      PH_BODY_B: return BODY_B_WORDS;
      PH_TAIL:   return TAIL_WORDS;
      default:   return 1;
    endcase
  endfunction

  assign dest_a   = (phase == PH_LEAD)   || (phase == PH_BODY_A);
  assign dest_b   = (phase == PH_BODY_B) || (phase == PH_TAIL);
  assign in_done  = (phase == PH_DONE);
  assign seg_last = (32'(seg_cnt) + 1 == seg_len(phase));

  always_comb begin
    if (start_i)     ready = 1'b0;
    else if (dest_a) ready = a_room;
    else if (dest_b) ready = b_room;
    else             ready = in_done;
  end

  assign fire = word_valid && ready;
  assign to_a = fire && dest_a;
  assign to_b = fire && dest_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      seg_cnt   <= '0;
      reps_left <= '0;
      err       <= 1'b0;
    end else if (start_i) begin
      phase     <= PH_LEAD;
      seg_cnt   <= '0;
      reps_left <= reps_i;
      err       <= 1'b0;
    end else if (fire) begin
      if (in_done) begin
        err <= 1'b1;
      end else if (!seg_last) begin
        seg_cnt <= seg_cnt + SGW'(1);
      end else begin
        seg_cnt <= '0;
        case (phase)
          PH_LEAD:   phase <= (reps_left == '0) ? PH_TAIL : PH_BODY_A;
          PH_BODY_A: phase <= PH_BODY_B;
          PH_BODY_B: begin
            reps_left <= reps_left - REP_W'(1);
            phase     <= (reps_left == REP_W'(1)) ? PH_TAIL : PH_BODY_A;
          end
          PH_TAIL:   phase <= PH_DONE;
          default:   phase <= phase;
        endcase
      end
    end
  end

endmodule

// File: rtl/stream_word_router.sv
module stream_word_router
  import swr_pkg::*;
#(
  parameter int BUS_W        = 32,
  parameter int A_SW         = 16,
  parameter int B_SW         = 8,
  parameter int A_DEPTH      = 20,
  parameter int B_DEPTH      = 20,
  parameter int LEAD_WORDS   = 1,
  parameter int BODY_A_WORDS = 10,
  parameter int BODY_B_WORDS = 5,
  parameter int TAIL_WORDS   = 1,
  parameter int REP_W        = 8,
  localparam int A_LANES     = BUS_W / A_SW,
  localparam int B_LANES     = BUS_W / B_SW,
  localparam int A_CW        = $clog2(A_DEPTH + 1),
  localparam int B_CW        = $clog2(B_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [REP_W-1:0] reps_i,
  input  logic             word_valid_i,
  input  logic [BUS_W-1:0] word_data_i,
  output logic             word_ready_o,
  input  logic             a_pop_i,
  output logic [A_SW-1:0]  a_data_o,
  output logic             a_valid_o,
  input  logic             b_pop_i,
  output logic [B_SW-1:0]  b_data_o,
  output logic             b_valid_o,
  output logic             err_o
);

  // Named internal events, used by the bound checker.
  logic            word_fire;
  logic            a_push, b_push;
  logic            a_room, b_room;
  logic            sched_done;
  logic [A_CW-1:0] a_level;
  logic [B_CW-1:0] b_level;

  swr_sched #(
    .LEAD_WORDS  (LEAD_WORDS),
    .BODY_A_WORDS(BODY_A_WORDS),
    .BODY_B_WORDS(BODY_B_WORDS),
    .TAIL_WORDS  (TAIL_WORDS),
    .REP_W       (REP_W)
  ) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .reps_i    (reps_i),
    .word_valid(word_valid_i),
    .a_room    (a_room),
    .b_room    (b_room),
    .ready     (word_ready_o),
    .fire      (word_fire),
    .to_a      (a_push),
    .to_b      (b_push),
    .in_done   (sched_done),
    .err       (err_o)
  );

  swr_fifo #(.SW(A_SW), .LANES(A_LANES), .DEPTH(A_DEPTH)) u_fifo_a (
    .clk  (clk),
    .rst_n(rst_n),
    .push (a_push),
    .din  (word_data_i),
    .pop  (a_pop_i),
    .dout (a_data_o),
    .valid(a_valid_o),
    .room (a_room),
    .level(a_level)
  );

  swr_fifo #(.SW(B_SW), .LANES(B_LANES), .DEPTH(B_DEPTH)) u_fifo_b (
    .clk  (clk),
    .rst_n(rst_n),
    .push (b_push),
    .din  (word_data_i),
    .pop  (b_pop_i),
    .dout (b_data_o),
    .valid(b_valid_o),
    .room (b_room),
    .level(b_level)
  );

endmodule

// File: rtl/stream_word_router_chk.sv
module stream_word_router_chk #(
  parameter int A_DEPTH = 20,
  parameter int B_DEPTH = 20,
  parameter int A_CW    = 5,
  parameter int B_CW    = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            word_ready_o,
  input logic            word_fire,
  input logic            a_push,
  input logic            b_push,
  input logic            a_room,
  input logic            b_room,
  input logic            sched_done,
  input logic            err_o,
  input logic [A_CW-1:0] a_level,
  input logic [B_CW-1:0] b_level
);

  // R6: a push never lands on a FIFO lacking room for the whole word
  a_r6_a_room: assert property (@(posedge clk) disable iff (!rst_n) a_push |-> a_room);
  a_r6_b_room: assert property (@(posedge clk) disable iff (!rst_n) b_push |-> b_room);

  // R7: occupancy never exceeds the stated depth
  a_r7_a_bound: assert property (@(posedge clk) disable iff (!rst_n) a_level <= A_CW'(A_DEPTH));
  a_r7_b_bound: assert property (@(posedge clk) disable iff (!rst_n) b_level <= B_CW'(B_DEPTH));

  // R3: a word goes to at most one stream
  a_r3_one_dest: assert property (@(posedge clk) disable iff (!rst_n) !(a_push && b_push));

  // R8: late word dropped, flag raised and held until start
  a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (word_fire && sched_done) |-> !(a_push || b_push));
  a_r8_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (word_fire && sched_done && !start_i) |=> err_o);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !start_i) |=> err_o);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n) start_i |=> !err_o);

  // R9: no acceptance while a start is applied
  a_r9_start_block: assert property (@(posedge clk) disable iff (!rst_n) start_i |-> !word_ready_o);

endmodule

bind stream_word_router stream_word_router_chk #(
  .A_DEPTH(A_DEPTH), .B_DEPTH(B_DEPTH), .A_CW(A_CW), .B_CW(B_CW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .word_ready_o(word_ready_o),
  .word_fire   (word_fire),
  .a_push      (a_push),
  .b_push      (b_push),
  .a_room      (a_room),
  .b_room      (b_room),
  .sched_done  (sched_done),
  .err_o       (err_o),
  .a_level     (a_level),
  .b_level     (b_level)
);

// File: tb/stream_word_router_test.sv
`timescale 1ns/1ps
module stream_word_router_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  reps_i = '0;
  logic        word_valid_i = 1'b0;
  logic [31:0] word_data_i = '0;
  logic        word_ready_o;
  logic        drain = 1'b1;
  logic [15:0] a_data_o;
  logic        a_valid_o;
  logic [7:0]  b_data_o;
  logic        b_valid_o;
  logic        err_o;

  int total = 0;
  int fails = 0;
  int na = 0;
  int nb = 0;
  logic [15:0] got_a [0:511];
  logic [7:0]  got_b [0:511];

  always #2.5 clk = ~clk;

  stream_word_router uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .reps_i(reps_i),
    .word_valid_i(word_valid_i), .word_data_i(word_data_i), .word_ready_o(word_ready_o),
    .a_pop_i(drain), .a_data_o(a_data_o), .a_valid_o(a_valid_o),
    .b_pop_i(drain), .b_data_o(b_data_o), .b_valid_o(b_valid_o),
    .err_o(err_o)
  );

  // Sample popped data away from the active edge.
  always @(negedge clk) begin
    if (drain && a_valid_o && na < 512) begin got_a[na] = a_data_o; na++; end
    if (drain && b_valid_o && nb < 512) begin got_b[nb] = b_data_o; nb++; end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Byte j of word k is {j, k[5:0]}: every sample in a run is distinct.
  function automatic logic [31:0] wgen(int k);
    logic [31:0] w;
    for (int j = 0; j < 4; j++) w[j*8 +: 8] = {2'(j), 6'(k)};
    return w;
  endfunction

  function automatic bit goes_a(int k, int r);
    if (k < 1) return 1'b1;
    if (k < 1 + 15*r) return ((k - 1) % 15) < 10;
    return 1'b0;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send_word(input logic [31:0] d);
    bit taken = 1'b0;
    word_valid_i = 1'b1;
    word_data_i  = d;
    while (!taken) begin
      @(negedge clk);
      if (word_ready_o) taken = 1'b1;
      tick();
    end
    word_valid_i = 1'b0;
  endtask

  task automatic do_start(input int r);
    start_i = 1'b1; reps_i = 8'(r);
    @(negedge clk);
    chk(word_ready_o == 1'b0, "R9 ready during start", word_ready_o, 0);
    tick();
    start_i = 1'b0;
  endtask

  task automatic compare_run(input int r, input int ba, input int bb);
    int ia = 0;
    int ib = 0;
    logic [15:0] ea [0:127];
    logic [7:0]  eb [0:255];
    for (int k = 0; k < 2 + 15*r; k++) begin
      logic [31:0] w;
      w = wgen(k);
      if (goes_a(k, r)) begin
        ea[ia] = w[15:0]; ea[ia+1] = w[31:16]; ia += 2;
      end else begin
        for (int j = 0; j < 4; j++) eb[ib+j] = w[j*8 +: 8];
        ib += 4;
      end
    end
    chk(na - ba == ia, "R3 A sample count", na - ba, ia);
    chk(nb - bb == ib, "R3 B sample count", nb - bb, ib);
    chk(got_a[ba] == wgen(0)[15:0], "R2 lead word first on A", got_a[ba], wgen(0)[15:0]);
    chk(got_b[nb-1] == wgen(1 + 15*r)[31:24], "R5 tail word last on B",
        got_b[nb-1], wgen(1 + 15*r)[31:24]);
    for (int i = 0; i < ia && i < na - ba; i++)
      chk(got_a[ba+i] == ea[i], "R4 A sample order", got_a[ba+i], ea[i]);
    for (int i = 0; i < ib && i < nb - bb; i++)
      chk(got_b[bb+i] == eb[i], "R4 B sample order", got_b[bb+i], eb[i]);
  endtask

  task automatic full_run(input int r);
    int ba, bb;
    ba = na; bb = nb;
    do_start(r);
    for (int k = 0; k < 2 + 15*r; k++) send_word(wgen(k));
    repeat (30) tick();
    compare_run(r, ba, bb);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int ba, bb, sa, sb;
    repeat (3) tick();
    rst_n = 1'b1;
    @(negedge clk);
    chk(word_ready_o == 1'b0, "R1 ready after reset", word_ready_o, 0);
    chk(a_valid_o == 1'b0, "R1 A empty", a_valid_o, 0);
    chk(b_valid_o == 1'b0, "R1 B empty", b_valid_o, 0);
    chk(err_o == 1'b0, "R1 err clear", err_o, 0);
    word_valid_i = 1'b1;
    @(negedge clk);
    chk(word_ready_o == 1'b0, "R9 idle not ready", word_ready_o, 0);
    tick();
    word_valid_i = 1'b0;

    // R3, R5: repetition sweep including the body-less case.
    for (int r = 0; r < 4; r++) full_run(r);

    // R6, R7: backpressure with A undrained.
    drain = 1'b0;
    ba = na; bb = nb;
    do_start(1);
    for (int k = 0; k < 10; k++) send_word(wgen(k));
    word_valid_i = 1'b1; word_data_i = wgen(10);
    repeat (3) @(negedge clk);
    chk(word_ready_o == 1'b0, "R6 stall when A full", word_ready_o, 0);
    chk(a_valid_o == 1'b1, "R7 20 A samples held", a_valid_o, 1);
    tick();
    drain = 1'b1;
    for (int k = 10; k < 17; k++) send_word(wgen(k));
    repeat (30) tick();
    compare_run(1, ba, bb);

    // R8: late word after tail.
    sa = na; sb = nb;
    send_word(32'hDEAD_BEEF);
    @(negedge clk);
    chk(err_o == 1'b1, "R8 err raised", err_o, 1);
    repeat (5) tick();
    chk(na == sa, "R8 no A sample from late word", na, sa);
    chk(nb == sb, "R8 no B sample from late word", nb, sb);
    chk(err_o == 1'b1, "R8 err sticky", err_o, 1);
    do_start(0);
    @(negedge clk);
    chk(err_o == 1'b0, "R8 err cleared by start", err_o, 0);
    tick();
    ba = na; bb = nb;
    for (int k = 0; k < 2; k++) send_word(wgen(k));
    repeat (20) tick();
    compare_run(0, ba, bb);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule